// File: doc/BRIEF.md
# Slot Status Event Counter Bank

This block keeps eight independent event counters for a time-triggered bus controller. During each communication cycle the protocol side reports one status vector per slot with a strobe. Each counter has its own condition, made of a select mask and a compare value. The counter advances by one for every reported slot whose selected status bits equal the selected compare bits.

Software never reads a counter while it is changing. At every cycle-start pulse, each counter's running value is copied into a host-visible snapshot register. After that copy, a per-counter accumulate bit decides what happens to the running value. With the bit at 0, the count restarts from zero in every cycle. With the bit at 1, it keeps growing across cycles and saturates instead of wrapping.

Leaving the configuration state zeroes every running count. Each counter also owns an event flag that is set when it advances and cleared by writing 1 to it. A mask selects which flags drive the shared interrupt line.

Top module: `slot_evt_bank`

## Requirements
- R1: After reset, every snapshot reads 0, every event flag is 0 and `irq` is 0.
- R2: When `status_vld` is 1, counter i advances by exactly one if `(status_vec & mask_i) == (value_i & mask_i)`, where mask_i and value_i are bits [i*8 +: 8] of `cond_mask` and `cond_value`. A cleared mask bit means "don't care", and a mask of 0 matches every strobe.
- R3: Snapshot i changes only on the clock in which `cycle_start` is 1. On that clock it takes the running count as it stood before the pulse. Strobes between pulses leave the snapshots unchanged.
- R4: On a cycle start, a counter whose `accum_en` bit is 0 restarts from 0 once its snapshot has been taken; a counter whose bit is 1 keeps its value. Clearing the bit therefore reports the full accumulated total at the next cycle start, and reports only that cycle's count at the one after.
- R5: A running count of 16'hFFFF stays at 16'hFFFF when further matches arrive. A snapshot never wraps to a small value.
- R6: A `cfg_exit` pulse zeroes every running count, whatever the accumulate bits are.
- R7: A strobe in the same clock as `cycle_start` (or `cfg_exit`) is counted in the new cycle, after the clear.
- R8: Flag i is set in the clock after counter i advances and holds until `flag_clr[i]` is 1. If a new advance coincides with the clear, the flag stays set. An advance that saturation suppresses does not set the flag.
- R9: `irq` is 1 exactly when some flag is set and its `irq_en` bit is 1.
- R10: The counters are independent: a strobe advances only those counters whose own conditions match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cycle_start | input | 1 | One-clock pulse at the start of a communication cycle |
| cfg_exit | input | 1 | One-clock pulse when the controller leaves configuration |
| status_vld | input | 1 | Slot status strobe |
| status_vec | input | 8 | Status vector of the slot being reported |
| cond_mask | input | 64 | Per-counter select masks, counter i at [i*8 +: 8] |
| cond_value | input | 64 | Per-counter compare values, counter i at [i*8 +: 8] |
| accum_en | input | 8 | Per-counter accumulate-across-cycles bit |
| irq_en | input | 8 | Per-counter interrupt enable |
| flag_clr | input | 8 | Write-1-to-clear pulses for the event flags |
| snap_flat | output | 128 | Snapshot registers, counter i at [i*16 +: 16] |
| irq_flags | output | 8 | Per-counter event flags |
| irq | output | 1 | Combined interrupt request |

## Verification
On every clock, assertions check the following:
- the running count moves by at most one between cycle boundaries;
- it stays pinned at its ceiling;
- it drops to at most one after a configuration exit or after a clearing cycle start;
- snapshots stay frozen between pulses and load the previous running value on a pulse;
- flags rise only after a match and fall only on a clear.

Only the bench scenarios can show the actual values that snapshots report. These scenarios cover several status patterns against distinct masks, the two-step reporting after the accumulate bit is cleared, and a strobe that coincides with a cycle start. They also cover saturation after more than 65535 matches and the masking of the interrupt line.

// File: rtl/slot_evt_pkg.sv
package slot_evt_pkg;
    localparam int NUM_CNT_DEF = 8;
    localparam int CNT_W_DEF   = 16;
    localparam int STS_W_DEF   = 8;
endpackage

// File: rtl/slot_evt_match.sv
module slot_evt_match #(
    parameter int STS_W = slot_evt_pkg::STS_W_DEF
) (
    input  logic             vld,
    input  logic [STS_W-1:0] vec,
    input  logic [STS_W-1:0] sel,
    input  logic [STS_W-1:0] want,
    output logic             hit
);
    logic [STS_W-1:0] diff;

    always_comb begin
        diff = (vec ^ want) & sel;
        hit  = vld && (diff == '0);
    end
endmodule

// File: rtl/slot_evt_counter.sv
module slot_evt_counter #(
    parameter int CNT_W = slot_evt_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cycle_start,
    input  logic             cfg_exit,
    input  logic             hit,
    input  logic             accum,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] snap,
    output logic             flag
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] snap;
        logic             flag;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CNT_W-1:0] base;
    logic             step_ok;

    always_comb begin
        st_d = st_q;
        base = st_q.cnt;
        if (cfg_exit)
            base = '0;
        else if (cycle_start && !accum)
            base = '0;
        step_ok = hit && (base != CNT_MAX);
        st_d.cnt  = step_ok ? base + 1'b1 : base;
        st_d.snap = cycle_start ? st_q.cnt : st_q.snap;
        st_d.flag = step_ok | (st_q.flag & ~flag_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign snap = st_q.snap;
    assign flag = st_q.flag;

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cycle_start && !cfg_exit) |=>
        (st_q.cnt == $past(st_q.cnt)) || (st_q.cnt == CNT_W'($past(st_q.cnt) + 1'b1))); // R2
    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cycle_start |=> $stable(st_q.snap)); // R3
    AST_SNAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |=> st_q.snap == $past(st_q.cnt)); // R3
    AST_CLEAR_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_start && !accum) |=> st_q.cnt <= CNT_W'(1)); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_MAX && !cycle_start && !cfg_exit) |=> st_q.cnt == CNT_MAX); // R5
    AST_CFG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_exit |=> st_q.cnt <= CNT_W'(1)); // R6
    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $past(hit)); // R8
    AST_FLAG_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && flag_clr && !hit) |=> !st_q.flag); // R8
endmodule

// File: rtl/slot_evt_bank.sv
module slot_evt_bank #(
    parameter int NUM_CNT = slot_evt_pkg::NUM_CNT_DEF,
    parameter int CNT_W   = slot_evt_pkg::CNT_W_DEF,
    parameter int STS_W   = slot_evt_pkg::STS_W_DEF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cycle_start,
    input  logic                     cfg_exit,
    input  logic                     status_vld,
    input  logic [STS_W-1:0]         status_vec,
    input  logic [NUM_CNT*STS_W-1:0] cond_mask,
    input  logic [NUM_CNT*STS_W-1:0] cond_value,
    input  logic [NUM_CNT-1:0]       accum_en,
    input  logic [NUM_CNT-1:0]       irq_en,
    input  logic [NUM_CNT-1:0]       flag_clr,
    output logic [NUM_CNT*CNT_W-1:0] snap_flat,
    output logic [NUM_CNT-1:0]       irq_flags,
    output logic                     irq
);
    logic [NUM_CNT-1:0] hit;

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        slot_evt_match #(.STS_W(STS_W)) u_match (
            .vld  (status_vld),
            .vec  (status_vec),
            .sel  (cond_mask[g*STS_W +: STS_W]),
            .want (cond_value[g*STS_W +: STS_W]),
            .hit  (hit[g])
        );

        slot_evt_counter #(.CNT_W(CNT_W)) u_counter (
            .clk         (clk),
            .rst_n       (rst_n),
            .cycle_start (cycle_start),
            .cfg_exit    (cfg_exit),
            .hit         (hit[g]),
            .accum       (accum_en[g]),
            .flag_clr    (flag_clr[g]),
            .snap        (snap_flat[g*CNT_W +: CNT_W]),
            .flag        (irq_flags[g])
        );
    end

    always_comb begin
        irq = |(irq_flags & irq_en);
    end

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |-> !irq); // R9
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_flags != '0)); // R9
endmodule

// File: tb/slot_evt_bank_tb.sv
`timescale 1ns/1ps
module slot_evt_bank_tb;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cycle_start = 1'b0;
    logic         cfg_exit = 1'b0;
    logic         status_vld = 1'b0;
    logic [7:0]   status_vec = '0;
    logic [63:0]  cond_mask;
    logic [63:0]  cond_value;
    logic [7:0]   accum_en = '0;
    logic [7:0]   irq_en = '0;
    logic [7:0]   flag_clr = '0;
    logic [127:0] snap_flat;
    logic [7:0]   irq_flags;
    logic         irq;

    logic [7:0]  b_mask [N];
    logic [7:0]  b_val  [N];
    logic [15:0] m_cnt  [N];
    logic [15:0] m_snap [N];
    logic [7:0]  m_flag;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            cond_mask[i*8 +: 8]  = b_mask[i];
            cond_value[i*8 +: 8] = b_val[i];
        end
    end

    slot_evt_bank u_dut (
        .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .cfg_exit(cfg_exit),
        .status_vld(status_vld), .status_vec(status_vec), .cond_mask(cond_mask),
        .cond_value(cond_value), .accum_en(accum_en), .irq_en(irq_en),
        .flag_clr(flag_clr), .snap_flat(snap_flat), .irq_flags(irq_flags), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_state(input string req);
        @(negedge clk);
        for (int i = 0; i < N; i++)
            chk(req, 32'(snap_flat[i*16 +: 16]), 32'(m_snap[i]));
        chk(req, 32'(irq_flags), 32'(m_flag));
        chk(req, 32'(irq), 32'(|(m_flag & irq_en)));
    endtask

    // one clock of stimulus; the model follows the requirement text
    task automatic step(input logic vld, input logic [7:0] st, input logic cs,
                        input logic ce, input logic [7:0] clr);
        @(negedge clk);
        status_vld = vld; status_vec = st; cycle_start = cs; cfg_exit = ce; flag_clr = clr;
        @(posedge clk);
        #1;
        for (int i = 0; i < N; i++) begin
            logic [15:0] base;
            logic        h, inc;
            base = m_cnt[i];
            if (ce) base = '0;
            else if (cs && !accum_en[i]) base = '0;
            h   = vld && ((st & b_mask[i]) == (b_val[i] & b_mask[i]));
            inc = h && (base != 16'hFFFF);
            if (cs) m_snap[i] = m_cnt[i];
            m_cnt[i]  = inc ? base + 16'd1 : base;
            m_flag[i] = inc | (m_flag[i] & ~clr[i]);
        end
        status_vld = 1'b0; cycle_start = 1'b0; cfg_exit = 1'b0; flag_clr = '0;
    endtask

    task automatic strobe(input logic [7:0] st); step(1'b1, st, 1'b0, 1'b0, 8'h00); endtask
    task automatic cstart();                    step(1'b0, 8'h00, 1'b1, 1'b0, 8'h00); endtask
    task automatic cexit();                     step(1'b0, 8'h00, 1'b0, 1'b1, 8'h00); endtask

    task automatic t_reset();
        chk_state("R1");
        chk("R1", 32'(irq), 32'd0);
    endtask

    task automatic t_patterns();
        accum_en = '0;
        b_mask[0] = 8'h0F; b_val[0] = 8'h05;
        b_mask[1] = 8'h80; b_val[1] = 8'h80;
        b_mask[2] = 8'h00; b_val[2] = 8'h00;
        for (int i = 3; i < N; i++) begin b_mask[i] = 8'hFF; b_val[i] = 8'hFF; end
        cexit();
        cstart();
        strobe(8'h05); strobe(8'h85); strobe(8'h15); strobe(8'h80); strobe(8'hFF);
        cstart();
        chk_state("R2");
        chk("R10", 32'(snap_flat[0 +: 16]), 32'd3);
        chk("R10", 32'(snap_flat[16 +: 16]), 32'd3);
        chk("R2", 32'(snap_flat[32 +: 16]), 32'd5);
        chk("R10", 32'(snap_flat[48 +: 16]), 32'd1);
    endtask

    task automatic t_hidden();
        strobe(8'h05); strobe(8'hFF); strobe(8'h00);
        chk_state("R3");
        chk("R3", 32'(snap_flat[32 +: 16]), 32'd5);
        cstart();
        chk_state("R3");
    endtask

    task automatic t_accum();
        for (int i = 0; i < N; i++) begin b_mask[i] = 8'h00; b_val[i] = 8'h00; end
        accum_en = 8'h01;
        cstart();
        strobe(8'h00); strobe(8'h00); strobe(8'h00);
        cstart();
        strobe(8'h00); strobe(8'h00);
        cstart();
        chk_state("R4");
        chk("R4", 32'(snap_flat[0 +: 16]), 32'd5);
        chk("R4", 32'(snap_flat[16 +: 16]), 32'd2);
        accum_en = 8'h00;
        strobe(8'h00);
        cstart();
        chk("R4", 32'(snap_flat[0 +: 16]), 32'd6);
        strobe(8'h00); strobe(8'h00);
        cstart();
        chk_state("R4");
        chk("R4", 32'(snap_flat[0 +: 16]), 32'd2);
    endtask

    task automatic t_same_clock();
        accum_en = '0;
        strobe(8'h00); strobe(8'h00);
        step(1'b1, 8'h00, 1'b1, 1'b0, 8'h00);
        chk("R7", 32'(snap_flat[32 +: 16]), 32'd2);
        cstart();
        chk_state("R7");
        chk("R7", 32'(snap_flat[32 +: 16]), 32'd1);
    endtask

    task automatic t_cfg_exit();
        accum_en = 8'hFF;
        strobe(8'h00); strobe(8'h00); strobe(8'h00); strobe(8'h00);
        cexit();
        strobe(8'h00);
        cstart();
        chk_state("R6");
        chk("R6", 32'(snap_flat[0 +: 16]), 32'd1);
        step(1'b1, 8'h00, 1'b0, 1'b1, 8'h00);
        cstart();
        chk("R7", 32'(snap_flat[0 +: 16]), 32'd1);
    endtask

    task automatic t_irq();
        step(1'b0, 8'h00, 1'b0, 1'b0, 8'hFF);
        chk_state("R8");
        chk("R8", 32'(irq_flags), 32'd0);
        b_mask[3] = 8'hFF; b_val[3] = 8'hAA;
        irq_en = 8'h00;
        strobe(8'hAA);
        chk_state("R9");
        chk("R9", 32'(irq), 32'd0);
        irq_en = 8'h08;
        chk_state("R9");
        chk("R9", 32'(irq), 32'd1);
        step(1'b0, 8'h00, 1'b0, 1'b0, 8'h01);
        chk_state("R8");
        chk("R9", 32'(irq), 32'd1);
        step(1'b1, 8'hAA, 1'b0, 1'b0, 8'h08);
        chk_state("R8");
        chk("R8", 32'(irq_flags[3]), 32'd1);
        step(1'b0, 8'h00, 1'b0, 1'b0, 8'h08);
        chk_state("R8");
        chk("R9", 32'(irq), 32'd0);
    endtask

    task automatic t_saturate();
        for (int i = 0; i < N; i++) begin b_mask[i] = 8'h00; b_val[i] = 8'h00; end
        b_mask[1] = 8'hFF; b_val[1] = 8'h11;
        accum_en = 8'h01;
        cexit();
        for (int k = 0; k < 65540; k++) strobe(8'h00);
        cstart();
        chk("R5", 32'(snap_flat[0 +: 16]), 32'hFFFF);
        step(1'b0, 8'h00, 1'b0, 1'b0, 8'hFF);
        strobe(8'h00); strobe(8'h00);
        cstart();
        chk_state("R5");
        chk("R5", 32'(snap_flat[0 +: 16]), 32'hFFFF);
        chk("R8", 32'(irq_flags[0]), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            b_mask[i] = '0; b_val[i] = '0; m_cnt[i] = '0; m_snap[i] = '0;
        end
        m_flag = '0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_patterns();
        t_hidden();
        t_accum();
        t_same_clock();
        t_cfg_exit();
        t_irq();
        t_saturate();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule